// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block sits beside an analog-to-digital converter and decides the cycle in which each conversion begins. It also paces the converter with a clock enable derived from the system clock. A configuration write loads a divide ratio, a start-mode code and an edge polarity all at once. While the burst flag is low, the start-mode code selects one of three behaviours. It can hold the converter idle, fire one conversion right away, or wait for a chosen edge on one of six external trigger lines. Those lines are two input pins and four timer match outputs.

Every trigger line is re-timed through a two-flop synchronizer before its edges are detected. The controller keeps a busy flag from the start pulse until the converter reports completion. Triggers that arrive during that window are dropped. All pins are plain control signals. There is no data stream and no back-pressure: the start pulse is a one-cycle strobe that the converter must accept.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, conv_start and conv_busy are 0. The stored divide value is 0, so conv_clk_en is 1 in every cycle.
- R2: With a stored divide value D, conv_clk_en is high for exactly one cycle out of every D+1 cycles.
- R3: A configuration write restarts the divider. conv_clk_en is low until the D-th cycle after the write cycle, is high in that cycle, and then repeats every D+1 cycles.
- R4: Start-mode code 0 never produces a start pulse, whatever the trigger lines do.
- R5: A write of start-mode code 1 produces exactly one start pulse. When the converter is idle, that pulse appears in the second cycle after the write cycle.
- R6: Codes 2 to 7 select trigger line trig_in[code-2]. Bits 0 and 1 are the input pins and bits 2 to 5 are the timer match outputs. Edges on lines that are not selected have no effect.
- R7: cfg_fall=0 selects rising edges and cfg_fall=1 selects falling edges. The start pulse appears in the third cycle after the selected line changes.
- R8: While burst_en is 1, no start pulse is produced. A pending code-1 start is discarded and does not fire after burst_en returns to 0.
- R9: conv_busy rises in the same cycle as conv_start and falls in the cycle after conv_done. Trigger edges while busy are ignored. A code-1 start written while busy is held and fires once the converter is idle.
- R10: conv_start is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 8 | Divide value; the converter clock is clk/(cfg_div+1) |
| cfg_mode | input | 3 | Start-mode code |
| cfg_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| burst_en | input | 1 | Burst flag; 1 disables start-mode control |
| trig_in | input | 6 | Asynchronous trigger lines: [1:0] pins, [5:2] timer matches |
| conv_done | input | 1 | Converter reports that its conversion has finished |
| conv_clk_en | output | 1 | Converter clock enable, one cycle per divide period |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_busy | output | 1 | A conversion is in progress |

## Verification
Divide values 0, 3 and 5 are loaded, one of them while a period is under way. This separates correct period length from correct reload timing. The trigger lines are toggled in several arrangements: a non-selected line next to the selected one, a rising edge under falling polarity, and edges inside a busy window. These arrangements show whether the multiplexer and the polarity are really decoded, rather than any edge starting a conversion. Code-1 writes are made while idle, while busy and while burst is set. These three cases separate a consumed one-shot, a held one-shot and a discarded one-shot.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int MODE_W    = 3;
  localparam int DIV_W     = 8;
  localparam int N_SRC     = 6;
  localparam int FIRST_EXT = 2;  // first code that selects an external line
  localparam logic [MODE_W-1:0] MODE_OFF = MODE_W'(0);
  localparam logic [MODE_W-1:0] MODE_NOW = MODE_W'(1);
endpackage

// File: rtl/atc_prescaler.sv
module atc_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] ratio_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      ratio_q <= load_val;
      cnt_q   <= load_val;
    end else if (cnt_q == '0) begin
      cnt_q   <= ratio_q;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/atc_edge_det.sv
module atc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/atc_start_sel.sv
module atc_start_sel
  import atc_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              fall_sel,
  input  logic [NSRC-1:0]   rise,
  input  logic [NSRC-1:0]   fall,
  input  logic              pend,
  input  logic              burst,
  input  logic              busy,
  output logic              fire
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (mode == MODE_W'(i + FIRST_EXT)) hit = fall_sel ? fall[i] : rise[i];
    end
    fire = 1'b0;
    if (!burst && !busy) begin
      if (mode == MODE_NOW)      fire = pend;
      else if (mode != MODE_OFF) fire = hit;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import atc_pkg::*;
#(
  parameter int DW          = DIV_W,
  parameter int NSRC        = N_SRC,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [DW-1:0]   cfg_div,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic            cfg_fall,
  input  logic            burst_en,
  input  logic [NSRC-1:0] trig_in,
  input  logic            conv_done,
  output logic            conv_clk_en,
  output logic            conv_start,
  output logic            conv_busy
);
  logic [MODE_W-1:0] mode_q;
  logic              fall_q;
  logic              pend_q;
  logic              busy_q;
  logic              start_q;
  logic [NSRC-1:0]   rise_v;
  logic [NSRC-1:0]   fall_v;
  logic              fire;

  atc_prescaler #(.W(DW)) u_presc (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .load_val(cfg_div), .tick(conv_clk_en)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    atc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(trig_in[g]), .rise(rise_v[g]), .fall(fall_v[g])
    );
  end

  atc_start_sel #(.NSRC(NSRC)) u_sel (
    .mode(mode_q), .fall_sel(fall_q), .rise(rise_v), .fall(fall_v),
    .pend(pend_q), .burst(burst_en), .busy(busy_q), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      fall_q  <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q <= cfg_mode;
        fall_q <= cfg_fall;
      end
      if (cfg_we && cfg_mode == MODE_NOW) pend_q <= 1'b1;
      else if (fire || burst_en)          pend_q <= 1'b0;
      if (fire)           busy_q <= 1'b1;
      else if (conv_done) busy_q <= 1'b0;
      start_q <= fire;
    end
  end

  assign conv_start = start_q;
  assign conv_busy  = busy_q;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
  import atc_pkg::*;
#(
  parameter int DW   = DIV_W,
  parameter int NSRC = N_SRC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [DW-1:0]     cfg_div,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              burst_en,
  input logic              conv_done,
  input logic              conv_clk_en,
  input logic              conv_start,
  input logic              conv_busy
);
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_busy_with_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_busy);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> conv_start);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && conv_done) |=> !conv_busy);

  assert_burst_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_en |=> !conv_start);

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_div != '0) |=> !conv_clk_en);

  assert_mode_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_mode == MODE_OFF) |=> ##1 !conv_start);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
  .burst_en(burst_en), .conv_done(conv_done), .conv_clk_en(conv_clk_en),
  .conv_start(conv_start), .conv_busy(conv_busy)
);

// File: tb/tb_adc_trig_ctrl.sv
`timescale 1ns/1ps
module tb_adc_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [2:0] cfg_mode = '0;
  logic       cfg_fall = 1'b0;
  logic       burst_en = 1'b0;
  logic [5:0] trig_in = '0;
  logic       conv_done = 1'b0;
  logic       conv_clk_en, conv_start, conv_busy;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int ticks = 0;
  int run = 0;
  int max_run = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  adc_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_fall(cfg_fall), .burst_en(burst_en), .trig_in(trig_in), .conv_done(conv_done),
    .conv_clk_en(conv_clk_en), .conv_start(conv_start), .conv_busy(conv_busy)
  );

  // behavioural reference, evaluated once per rising edge
  int         m_div, m_cnt, m_mode;
  bit         m_fall, m_pend, m_busy, m_start, f;
  bit [5:0]   h1, h2, h3, ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_mode = 0; m_fall = 0;
      m_pend = 0; m_busy = 0; m_start = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      ev = m_fall ? (~h2 & h3) : (h2 & ~h3);
      f = 0;
      if (!burst_en && !m_busy) begin
        if (m_mode == 1)      f = m_pend;
        else if (m_mode >= 2) f = ev[m_mode-2];
      end
      m_start = f;
      if (f) m_busy = 1;
      else if (conv_done) m_busy = 0;
      if (cfg_we && cfg_mode == 3'd1) m_pend = 1;
      else if (f || burst_en) m_pend = 0;
      if (cfg_we) begin
        m_div = cfg_div; m_cnt = cfg_div; m_mode = cfg_mode; m_fall = cfg_fall;
      end else if (m_cnt == 0) m_cnt = m_div;
      else m_cnt = m_cnt - 1;
      h3 = h2; h2 = h1; h1 = trig_in;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({cur_req, " clk_en"}, conv_clk_en, (m_cnt == 0));
      chk({cur_req, " start"}, conv_start, m_start);
      chk({cur_req, " busy"}, conv_busy, m_busy);
      if (conv_start) begin pulses++; run++; end else run = 0;
      if (run > max_run) max_run = run;
      if (conv_clk_en) ticks++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int div, int mode, bit fall);
    cfg_div = 8'(div); cfg_mode = 3'(mode); cfg_fall = fall; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1; cyc(1); conv_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int p0, t0, k;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    cur_req = "R1";
    chk("R1 start", conv_start, 0);
    chk("R1 busy", conv_busy, 0);
    t0 = ticks; cyc(10);
    chk("R1 clk_en every cycle", ticks - t0, 10);

    // R3 reload timing and R2 period
    cur_req = "R3";
    wr(3, 0, 0);
    k = 0;
    while (!conv_clk_en && k < 20) begin cyc(1); k++; end
    chk("R3 cycles to first clk_en D=3", k, 3);
    cur_req = "R2";
    t0 = ticks; cyc(40);
    chk("R2 clk_en count D=3", ticks - t0, 10);
    cur_req = "R3";
    cyc(2);
    wr(5, 0, 0);
    k = 0;
    while (!conv_clk_en && k < 20) begin cyc(1); k++; end
    chk("R3 cycles to first clk_en D=5 mid-period", k, 5);
    cur_req = "R2";
    t0 = ticks; cyc(60);
    chk("R2 clk_en count D=5", ticks - t0, 10);

    // R4 mode off
    cur_req = "R4";
    wr(0, 0, 0);
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      trig_in[i] = 1'b1; cyc(5); trig_in[i] = 1'b0; cyc(5);
    end
    chk("R4 no start in mode 0", pulses - p0, 0);
    chk("R4 busy stays low", conv_busy, 0);

    // R5 immediate one-shot
    cur_req = "R5";
    p0 = pulses;
    wr(0, 1, 0);
    cyc(1);
    chk("R5 start in second cycle after write", conv_start, 1);
    cyc(20);
    done_pulse();
    cyc(20);
    chk("R5 exactly one pulse", pulses - p0, 1);

    // R6 source selection, R7 rising
    cur_req = "R6";
    wr(0, 3, 0);
    p0 = pulses;
    trig_in[0] = 1'b1; cyc(6); trig_in[0] = 1'b0; cyc(6);
    trig_in[2] = 1'b1; cyc(6); trig_in[2] = 1'b0; cyc(6);
    chk("R6 unselected lines ignored", pulses - p0, 0);
    cur_req = "R7";
    trig_in[1] = 1'b1;
    cyc(2);
    chk("R7 no start before third cycle", conv_start, 0);
    cyc(1);
    chk("R7 rising edge start in third cycle", conv_start, 1);
    cyc(4);
    chk("R6 selected pin starts once", pulses - p0, 1);
    done_pulse();
    trig_in[1] = 1'b0; cyc(6);
    chk("R7 falling edge ignored with rising polarity", pulses - p0, 1);

    // R7 falling polarity on a timer line
    cur_req = "R7";
    wr(0, 6, 1);
    p0 = pulses;
    trig_in[4] = 1'b1; cyc(6);
    chk("R7 rising ignored with falling polarity", pulses - p0, 0);
    trig_in[4] = 1'b0; cyc(6);
    chk("R7 falling edge starts", pulses - p0, 1);

    // R9 edges while busy, held one-shot
    cur_req = "R9";
    trig_in[4] = 1'b1; cyc(4); trig_in[4] = 1'b0; cyc(6);
    chk("R9 edge while busy ignored", pulses - p0, 1);
    chk("R9 busy held", conv_busy, 1);
    wr(0, 1, 0);
    cyc(5);
    chk("R9 one-shot held while busy", pulses - p0, 1);
    done_pulse();
    cyc(5);
    chk("R9 held one-shot fires when idle", pulses - p0, 2);
    done_pulse();
    chk("R9 busy falls after done", conv_busy, 0);

    // R8 burst
    cur_req = "R8";
    burst_en = 1'b1;
    p0 = pulses;
    wr(0, 1, 0);
    cyc(10);
    burst_en = 1'b0;
    cyc(10);
    chk("R8 burst discards one-shot", pulses - p0, 0);
    wr(0, 2, 0);
    burst_en = 1'b1;
    trig_in[0] = 1'b1; cyc(6); trig_in[0] = 1'b0; cyc(6);
    chk("R8 burst blocks edge start", pulses - p0, 0);
    burst_en = 1'b0;

    cur_req = "R10";
    chk("R10 longest start run", max_run, 1);
    cyc(5);
    summary();
  end
endmodule